// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits at the entry of the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where the operand value comes from. There are three possible sources. The first is the value read from the register file. The second is the result held in the EX/MEM pipeline register, written by the instruction one step ahead. The third is the result held in the MEM/WB pipeline register, written by the instruction two steps ahead. The decision is purely combinational. It uses the source register numbers of the instruction entering execute, the destination register numbers and write-enable flags of the two older instructions, and a two-bit instruction class that says which source operands the instruction actually reads.

The top level wraps the select logic together with the two operand multiplexers, so it can be checked end to end. A control module compares register numbers and emits a small set of forwarding strobes. A datapath module turns those strobes into the 2-bit select codes and the chosen operand values.

Top module: `opfwd_top`

## Requirements
- R1: When an operand is read and the EX/MEM stage writes a nonzero destination equal to that operand's source register, the operand's select is 2'b10 and the operand carries the EX/MEM result.
- R2: When an operand is read, EX/MEM does not supply it, and MEM/WB writes a nonzero destination equal to its source register, the select is 2'b01 and the operand carries the MEM/WB result.
- R3: When both EX/MEM and MEM/WB write the register an operand needs, the newer EX/MEM result wins (select 2'b10).
- R4: A destination register number of 0 never causes forwarding from either stage.
- R5: A stage whose write-enable flag is low never forwards, whatever its destination number.
- R6: For class 2'b01 (immediate arithmetic) and class 2'b10 (load or store), only the first operand is checked; the second operand's select stays 2'b00 even when its register number matches.
- R7: For class 2'b11 (branch compare) and class 2'b00 (register-register), both operands are checked independently and may forward from different stages in the same cycle.
- R8: With no qualifying match, the select is 2'b00 and the operand carries the register file value.
- R9: Each operand output always equals the source named by its select: 2'b00 register file, 2'b10 EX/MEM result, 2'b01 MEM/WB result.
- R10: Selects and operands depend only on the current inputs and follow an input change within the same clock period, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcRegA | input | 5 | First source register number of the instruction in execute |
| srcRegB | input | 5 | Second source register number of the instruction in execute |
| instrClass | input | 2 | 00 register-register, 01 immediate, 10 load/store, 11 branch |
| exMemDst | input | 5 | Destination register of the EX/MEM instruction |
| exMemWrEn | input | 1 | EX/MEM instruction writes a register |
| memWbDst | input | 5 | Destination register of the MEM/WB instruction |
| memWbWrEn | input | 1 | MEM/WB instruction writes a register |
| rfDataA | input | 32 | Register file value for the first operand |
| rfDataB | input | 32 | Register file value for the second operand |
| exMemData | input | 32 | Result held in EX/MEM |
| memWbData | input | 32 | Result held in MEM/WB |
| selA | output | 2 | Source select for the first operand |
| selB | output | 2 | Source select for the second operand |
| operandA | output | 32 | First ALU operand after forwarding |
| operandB | output | 32 | Second ALU operand after forwarding |

## Verification
Two forwarding paths can become valid in the same cycle, and the tests cover both ways this happens. In the first, both older stages write the same register that one operand needs, so the priority rule must pick EX/MEM. In the second, the two operands forward from different stages at once, for example A from EX/MEM and B from MEM/WB in a register-register or branch instruction. Directed cycles set up each of these overlaps, including overlaps where the EX/MEM match is disqualified by register 0 or by a low write flag. A long run of cycles drawn from a small register range then makes such overlaps frequent. In every cycle the bench compares the selects and operand values with a behavioural model.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    FWD_REGFILE = 2'b00,
    FWD_MEMWB   = 2'b01,
    FWD_EXMEM   = 2'b10
  } fwdSel_e;

  typedef enum logic [1:0] {
    CLS_REGREG = 2'b00,
    CLS_IMM    = 2'b01,
    CLS_MEMOP  = 2'b10,
    CLS_BRANCH = 2'b11
  } instrClass_e;

  typedef struct packed {
    logic [NUM_OPS-1:0] takeExMem;
    logic [NUM_OPS-1:0] takeMemWb;
  } fwdStrobes_t;

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match #(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  needed,
  input  logic [REG_ADDR_W-1:0] srcReg,
  input  logic [REG_ADDR_W-1:0] dstReg,
  input  logic                  wrEn,
  output logic                  hit
);
  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic dstLive;
  assign dstLive = wrEn && (dstReg != ZERO_REG);
  assign hit     = needed && dstLive && (dstReg == srcReg);
endmodule

// File: rtl/opfwd_ctrl.sv
module opfwd_ctrl
  import opfwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] srcRegA,
  input  logic [REG_ADDR_W-1:0] srcRegB,
  input  logic [1:0]            instrClass,
  input  logic [REG_ADDR_W-1:0] exMemDst,
  input  logic                  exMemWrEn,
  input  logic [REG_ADDR_W-1:0] memWbDst,
  input  logic                  memWbWrEn,
  output fwdStrobes_t           strobes
);
  instrClass_e          cls;
  logic [NUM_OPS-1:0]   opRead;
  logic [REG_ADDR_W-1:0] srcReg [NUM_OPS];
  logic [NUM_OPS-1:0]   exHit;
  logic [NUM_OPS-1:0]   wbHit;

  assign cls       = instrClass_e'(instrClass);
  assign srcReg[0] = srcRegA;
  assign srcReg[1] = srcRegB;

  always_comb begin
    unique case (cls)
      CLS_REGREG, CLS_BRANCH: opRead = 2'b11;
      CLS_IMM, CLS_MEMOP:     opRead = 2'b01;
      default:                opRead = 2'b01;
    endcase
  end

  generate
    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
      opfwd_match #(.REG_ADDR_W(REG_ADDR_W)) u_exMatch (
        .needed (opRead[op]),
        .srcReg (srcReg[op]),
        .dstReg (exMemDst),
        .wrEn   (exMemWrEn),
        .hit    (exHit[op])
      );
      opfwd_match #(.REG_ADDR_W(REG_ADDR_W)) u_wbMatch (
        .needed (opRead[op]),
        .srcReg (srcReg[op]),
        .dstReg (memWbDst),
        .wrEn   (memWbWrEn),
        .hit    (wbHit[op])
      );
      assign strobes.takeExMem[op] = exHit[op];
      assign strobes.takeMemWb[op] = wbHit[op] && !exHit[op];
    end
  endgenerate
endmodule

// File: rtl/opfwd_datapath.sv
module opfwd_datapath
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] exMemData,
  input  logic [DATA_W-1:0] memWbData,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic [DATA_W-1:0] operandA,
  output logic [DATA_W-1:0] operandB
);
  logic [DATA_W-1:0] rfData  [NUM_OPS];
  logic [DATA_W-1:0] opData  [NUM_OPS];
  fwdSel_e           selCode [NUM_OPS];

  assign rfData[0] = rfDataA;
  assign rfData[1] = rfDataB;

  generate
    for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
      always_comb begin
        if (strobes.takeExMem[op])      selCode[op] = FWD_EXMEM;
        else if (strobes.takeMemWb[op]) selCode[op] = FWD_MEMWB;
        else                            selCode[op] = FWD_REGFILE;
      end
      always_comb begin
        unique case (selCode[op])
          FWD_EXMEM: opData[op] = exMemData;
          FWD_MEMWB: opData[op] = memWbData;
          default:   opData[op] = rfData[op];
        endcase
      end
    end
  endgenerate

  assign selA     = selCode[0];
  assign selB     = selCode[1];
  assign operandA = opData[0];
  assign operandB = opData[1];
endmodule

// File: rtl/opfwd_top.sv
module opfwd_top
  import opfwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input  logic [REG_ADDR_W-1:0] srcRegA,
  input  logic [REG_ADDR_W-1:0] srcRegB,
  input  logic [1:0]            instrClass,
  input  logic [REG_ADDR_W-1:0] exMemDst,
  input  logic                  exMemWrEn,
  input  logic [REG_ADDR_W-1:0] memWbDst,
  input  logic                  memWbWrEn,
  input  logic [DATA_W-1:0]     rfDataA,
  input  logic [DATA_W-1:0]     rfDataB,
  input  logic [DATA_W-1:0]     exMemData,
  input  logic [DATA_W-1:0]     memWbData,
  output logic [1:0]            selA,
  output logic [1:0]            selB,
  output logic [DATA_W-1:0]     operandA,
  output logic [DATA_W-1:0]     operandB
);
  fwdStrobes_t strobes;

  opfwd_ctrl #(.REG_ADDR_W(REG_ADDR_W)) u_ctrl (
    .srcRegA    (srcRegA),
    .srcRegB    (srcRegB),
    .instrClass (instrClass),
    .exMemDst   (exMemDst),
    .exMemWrEn  (exMemWrEn),
    .memWbDst   (memWbDst),
    .memWbWrEn  (memWbWrEn),
    .strobes    (strobes)
  );

  opfwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes   (strobes),
    .rfDataA   (rfDataA),
    .rfDataB   (rfDataB),
    .exMemData (exMemData),
    .memWbData (memWbData),
    .selA      (selA),
    .selB      (selB),
    .operandA  (operandA),
    .operandB  (operandB)
  );
endmodule

// File: rtl/opfwd_checker.sv
module opfwd_checker #(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input logic [REG_ADDR_W-1:0] srcRegA,
  input logic [REG_ADDR_W-1:0] srcRegB,
  input logic [1:0]            instrClass,
  input logic [REG_ADDR_W-1:0] exMemDst,
  input logic                  exMemWrEn,
  input logic [REG_ADDR_W-1:0] memWbDst,
  input logic                  memWbWrEn,
  input logic [DATA_W-1:0]     rfDataA,
  input logic [DATA_W-1:0]     rfDataB,
  input logic [DATA_W-1:0]     exMemData,
  input logic [DATA_W-1:0]     memWbData,
  input logic [1:0]            selA,
  input logic [1:0]            selB,
  input logic [DATA_W-1:0]     operandA,
  input logic [DATA_W-1:0]     operandB
);
  logic bRead;
  assign bRead = (instrClass == 2'b00) || (instrClass == 2'b11);

  always_comb begin
    // R1 and R3: a live EX/MEM match on operand A always takes the newest value
    if (exMemWrEn && exMemDst != '0 && exMemDst == srcRegA)
      a_r3_exmem_wins: assert (selA == 2'b10);
    // R4 and R5: forwarding from EX/MEM needs a live nonzero destination
    if (selA == 2'b10 || selB == 2'b10)
      a_r4_exmem_live: assert (exMemWrEn && exMemDst != '0);
    if (selA == 2'b01 || selB == 2'b01)
      a_r5_memwb_live: assert (memWbWrEn && memWbDst != '0);
    // R6: classes that read one operand leave B on the register file
    if (!bRead)
      a_r6_b_unused: assert (selB == 2'b00);
    // R9: operand values follow the select codes
    a_r9_mux_a: assert ((selA == 2'b10) ? (operandA == exMemData) :
                        (selA == 2'b01) ? (operandA == memWbData) :
                                          (operandA == rfDataA));
    a_r9_mux_b: assert ((selB == 2'b10) ? (operandB == exMemData) :
                        (selB == 2'b01) ? (operandB == memWbData) :
                                          (operandB == rfDataB));
    a_r9_legal_codes: assert (selA != 2'b11 && selB != 2'b11);
    // R2: MEM/WB is used only when the select points to a stage matching B's source
    if (selB == 2'b01)
      a_r2_memwb_b_match: assert (memWbDst == srcRegB && bRead);
  end
endmodule

bind opfwd_top opfwd_checker #(.REG_ADDR_W(REG_ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/opfwd_top_test.sv
module opfwd_top_test;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] srcRegA, srcRegB, exMemDst, memWbDst;
  logic [1:0]    instrClass;
  logic          exMemWrEn, memWbWrEn;
  logic [DW-1:0] rfDataA, rfDataB, exMemData, memWbData;
  logic [1:0]    selA, selB;
  logic [DW-1:0] operandA, operandB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  opfwd_top #(.REG_ADDR_W(AW), .DATA_W(DW)) uut (.*);

  function automatic logic [1:0] refSel(input int idx);
    bit used;
    logic [AW-1:0] src;
    used = (idx == 0) || (instrClass == 2'b00) || (instrClass == 2'b11);
    src  = (idx == 0) ? srcRegA : srcRegB;
    if (!used) return 2'b00;
    if (exMemWrEn && exMemDst != 0 && exMemDst == src) return 2'b10;
    if (memWbWrEn && memWbDst != 0 && memWbDst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] refData(input int idx, input logic [1:0] s);
    if (s == 2'b10) return exMemData;
    if (s == 2'b01) return memWbData;
    return (idx == 0) ? rfDataA : rfDataB;
  endfunction

  task automatic checkNow(input string tag);
    logic [1:0] eA, eB;
    eA = refSel(0);
    eB = refSel(1);
    checks += 4;
    if (selA !== eA) begin errors++; $display("FAIL %s selA actual=%b expected=%b", tag, selA, eA); end
    if (selB !== eB) begin errors++; $display("FAIL %s selB actual=%b expected=%b", tag, selB, eB); end
    if (operandA !== refData(0, eA)) begin
      errors++; $display("FAIL R9/%s operandA actual=%h expected=%h", tag, operandA, refData(0, eA));
    end
    if (operandB !== refData(1, eB)) begin
      errors++; $display("FAIL R9/%s operandB actual=%h expected=%h", tag, operandB, refData(1, eB));
    end
  endtask

  task automatic drive(input logic [1:0] cls, input int a, input int b,
                       input int exD, input bit exW, input int wbD, input bit wbW);
    instrClass = cls;
    srcRegA = AW'(a); srcRegB = AW'(b);
    exMemDst = AW'(exD); exMemWrEn = exW;
    memWbDst = AW'(wbD); memWbWrEn = wbW;
  endtask

  task automatic cycle(input logic [1:0] cls, input int a, input int b,
                       input int exD, input bit exW, input int wbD, input bit wbW,
                       input string tag);
    @(posedge clk); #1;
    drive(cls, a, b, exD, exW, wbD, wbW);
    @(negedge clk);
    checkNow(tag);
  endtask

  initial begin
    rfDataA = 32'hAAAA_0001; rfDataB = 32'hBBBB_0002;
    exMemData = 32'hE0E0_0003; memWbData = 32'h5050_0004;
    drive(2'b00, 0, 0, 0, 1'b0, 0, 1'b0);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkNow("R8 reset-state");
    cycle(2'b00, 3, 4, 3, 1, 9, 1, "R1");
    cycle(2'b00, 3, 4, 4, 1, 9, 1, "R1");
    cycle(2'b00, 3, 4, 9, 1, 3, 1, "R2");
    cycle(2'b00, 3, 4, 9, 1, 4, 1, "R2");
    cycle(2'b00, 7, 7, 7, 1, 7, 1, "R3");
    cycle(2'b11, 6, 2, 6, 1, 6, 1, "R3");
    cycle(2'b00, 0, 0, 0, 1, 0, 1, "R4");
    cycle(2'b00, 0, 5, 0, 1, 5, 1, "R4");
    cycle(2'b00, 5, 5, 5, 0, 5, 1, "R5");
    cycle(2'b00, 5, 6, 5, 0, 6, 0, "R5");
    cycle(2'b01, 8, 9, 9, 1, 9, 1, "R6");
    cycle(2'b10, 8, 9, 8, 1, 9, 1, "R6");
    cycle(2'b10, 8, 9, 1, 1, 8, 1, "R6");
    cycle(2'b11, 10, 11, 10, 1, 11, 1, "R7");
    cycle(2'b11, 10, 11, 11, 1, 10, 1, "R7");
    cycle(2'b00, 12, 13, 13, 1, 12, 1, "R7");
    cycle(2'b00, 1, 2, 3, 1, 4, 1, "R8");
    // R10: two input changes within one clock period, each observed before the next edge
    @(posedge clk); #1;
    drive(2'b00, 14, 15, 14, 1, 15, 1);
    #2 checkNow("R10 first change");
    drive(2'b00, 14, 15, 15, 1, 14, 1);
    #2 checkNow("R10 second change");
    exMemData = 32'h1234_5678;
    #1 checkNow("R10 data change");
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      rfDataA = $urandom; rfDataB = $urandom;
      exMemData = $urandom; memWbData = $urandom;
      drive(2'($urandom), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom));
      @(negedge clk);
      checkNow("R9 random");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule